// File: doc/BRIEF.md
# Row-to-Row Operand Routing Fabric

This block carries operand words one way, from the W processing elements of one row of a reconfigurable datapath array down to the W elements of the next row. Each lower-row element has two operand ports, and the fabric delivers one word to each of them. The fabric is not a full crossbar. Every source first passes through a one-input, two-output steering cell that places it on lane A (feeding the first operand ports) or lane B (feeding the second operand ports). Each lane then passes through MCL stages of two-input, two-output exchange cells that link neighbouring columns. Every stage, the steering stage included, ends in a two-register hop.

Because a word can move at most one column in each exchange stage, a destination only ever sees sources within MCL columns of its own column. Every route has the same number of register hops, so the two operands that reach one element always arrive together. Switch settings enter through a serial shift chain that is separate from the data path. They drive the fabric only after a load strobe copies the chain into the active setting register. The tail of the chain is brought out so that the chains of several rows can be daisy-chained.

Top module: `orn_row_link`

## Requirements
- R1: While `rst` is high, and on the clock edge that samples it, `dst_a`, `dst_b`, the shift chain and the active setting all clear to zero. After reset the fabric therefore routes source j to `dst_a` word j, and `dst_b` stays zero.
- R2: The latency from `src_data` to `dst_a`/`dst_b` is exactly 2*(MCL+1) clock edges for every route. A word held for a single cycle appears for exactly one cycle, 2*(MCL+1) edges after the edge that captured it.
- R3: Active bit j (0 <= j < W) steers source word j. A value of 0 places it on lane A and 1 places it on lane B. The lane that is not selected carries zero in that column.
- R4: Exchange stage k (0 <= k < MCL) pairs columns (k%2+2p, k%2+2p+1) for every pair that fits within W. A pair bit of 0 passes both words straight through, and 1 swaps them. Lane A's final stage drives `dst_a`, and lane B's final stage drives `dst_b` (word i at bits [i*DW +: DW]).
- R5: A source word that reaches a destination column lands at most MCL columns away from its own column.
- R6: Setting layout: bits [W-1:0] are the steering bits. Lane A's pair bits follow from bit W, stage 0 first and pair index ascending, and lane B's pair bits follow in the same order after lane A's.
- R7: With `cfg_shift` high, the chain shifts left by one and `cfg_sdi` enters bit 0, so a vector sent most significant bit first ends up in place after CFG_W shifts. Shifting alone never changes the routing.
- R8: A `cfg_load` pulse copies the chain into the active setting. The new routing applies to words captured from the next edge onward.
- R9: `cfg_sdo` presents the chain's most significant bit.
- R10: Each lane only permutes words. No stage creates, drops or duplicates a word, and the word sum of a lane is preserved from one hop to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sdi | input | 1 | Serial setting bit into the chain |
| cfg_shift | input | 1 | Shift the chain by one bit |
| cfg_load | input | 1 | Copy the chain into the active setting |
| cfg_sdo | output | 1 | Chain tail (most significant bit) for daisy-chaining |
| src_data | input | W*DW | Upper-row words, word j at bits [j*DW +: DW] |
| dst_a | output | W*DW | First operand for each lower-row element |
| dst_b | output | W*DW | Second operand for each lower-row element |

## Verification
The conservation checks compare lane sums across each two-register hop. They assume that the active setting does not change while a word is between hops, so they hold only when loads fall on a drained or steady stream. The bench satisfies this by keeping `src_data` constant across every load and by waiting well beyond the route latency before it samples. The single-cycle pulse used for the latency check is sent only after the routing has settled. The checks that shifting and loading leave the routing unchanged assume that `cfg_shift` and `cfg_load` are never X outside reset. The bench drives both to defined levels from time zero.

// File: rtl/orn_pkg.sv
package orn_pkg;

    // Lane selection for the steering cell
    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_e;

    localparam int LANES = 2;

    // Number of neighbour pairs handled by exchange stage k
    function automatic int pairs_in_stage(input int w, input int k);
        return (w - (k % 2)) / 2;
    endfunction

    // Offset of stage k's pair bits inside one lane's setting field
    function automatic int stage_cfg_base(input int w, input int k);
        int acc;
        acc = 0;
        for (int m = 0; m < k; m++) acc += pairs_in_stage(w, m);
        return acc;
    endfunction

    function automatic int lane_cfg_bits(input int w, input int mcl);
        return stage_cfg_base(w, mcl);
    endfunction

    function automatic int total_cfg_bits(input int w, input int mcl);
        return w + LANES * lane_cfg_bits(w, mcl);
    endfunction

endpackage

// File: rtl/orn_hop_delay.sv
module orn_hop_delay #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] first_q;
    logic [WIDTH-1:0] second_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= '0;
            second_q <= '0;
        end else begin
            first_q  <= d;
            second_q <= first_q;
        end
    end

    assign q = second_q;
endmodule

// File: rtl/orn_cfg_chain.sv
module orn_cfg_chain #(
    parameter int CFG_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sdi,
    input  logic             shift,
    input  logic             load,
    output logic [CFG_W-1:0] chain_q,
    output logic [CFG_W-1:0] act_q,
    output logic             sdo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            act_q   <= '0;
        end else begin
            if (shift) chain_q <= {chain_q[CFG_W-2:0], sdi};
            if (load)  act_q   <= chain_q;
        end
    end

    assign sdo = chain_q[CFG_W-1];
endmodule

// File: rtl/orn_steer_stage.sv
module orn_steer_stage
    import orn_pkg::*;
#(
    parameter int W  = 8,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [W-1:0]          sel,
    input  logic [W-1:0][DW-1:0]  src,
    output logic [W-1:0][DW-1:0]  lane_a,
    output logic [W-1:0][DW-1:0]  lane_b
);
    logic [W-1:0][DW-1:0] to_a;
    logic [W-1:0][DW-1:0] to_b;

    for (genvar j = 0; j < W; j++) begin : g_cell
        assign to_a[j] = (lane_e'(sel[j]) == LANE_A) ? src[j] : '0;
        assign to_b[j] = (lane_e'(sel[j]) == LANE_B) ? src[j] : '0;
    end

    orn_hop_delay #(.WIDTH(2 * W * DW)) hop_i (
        .clk (clk),
        .rst (rst),
        .d   ({to_b, to_a}),
        .q   ({lane_b, lane_a})
    );
endmodule

// File: rtl/orn_swap_stage.sv
module orn_swap_stage
    import orn_pkg::*;
#(
    parameter int W  = 8,
    parameter int DW = 16,
    parameter int K  = 0
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [pairs_in_stage(W, K)-1:0]     swap,
    input  logic [W-1:0][DW-1:0]                d,
    output logic [W-1:0][DW-1:0]                q
);
    localparam int OFF = K % 2;
    localparam int NP  = pairs_in_stage(W, K);

    logic [W-1:0][DW-1:0] mixed;

    for (genvar c = 0; c < W; c++) begin : g_col
        if (c < OFF || c >= OFF + 2 * NP) begin : g_pass
            assign mixed[c] = d[c];
        end else if (((c - OFF) % 2) == 0) begin : g_low
            assign mixed[c] = swap[(c - OFF) / 2] ? d[c+1] : d[c];
        end else begin : g_high
            assign mixed[c] = swap[(c - OFF) / 2] ? d[c-1] : d[c];
        end
    end

    orn_hop_delay #(.WIDTH(W * DW)) hop_i (
        .clk (clk),
        .rst (rst),
        .d   (mixed),
        .q   (q)
    );
endmodule

// File: rtl/orn_row_link.sv
module orn_row_link
    import orn_pkg::*;
#(
    parameter int W   = 8,
    parameter int DW  = 16,
    parameter int MCL = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_sdi,
    input  logic            cfg_shift,
    input  logic            cfg_load,
    output logic            cfg_sdo,
    input  logic [W*DW-1:0] src_data,
    output logic [W*DW-1:0] dst_a,
    output logic [W*DW-1:0] dst_b
);
    localparam int LANE_BITS = lane_cfg_bits(W, MCL);
    localparam int CFG_W     = total_cfg_bits(W, MCL);

    logic [CFG_W-1:0] chain_q;
    logic [CFG_W-1:0] act_cfg;

    // lane_tap[lane][hop]: hop 0 is after steering, hop MCL is the final output
    logic [LANES-1:0][MCL:0][W-1:0][DW-1:0] lane_tap;

    orn_cfg_chain #(.CFG_W(CFG_W)) chain_i (
        .clk     (clk),
        .rst     (rst),
        .sdi     (cfg_sdi),
        .shift   (cfg_shift),
        .load    (cfg_load),
        .chain_q (chain_q),
        .act_q   (act_cfg),
        .sdo     (cfg_sdo)
    );

    orn_steer_stage #(.W(W), .DW(DW)) steer_i (
        .clk    (clk),
        .rst    (rst),
        .sel    (act_cfg[W-1:0]),
        .src    (src_data),
        .lane_a (lane_tap[0][0]),
        .lane_b (lane_tap[1][0])
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar k = 0; k < MCL; k++) begin : g_stage
            localparam int NPK  = pairs_in_stage(W, k);
            localparam int BASE = W + l * LANE_BITS + stage_cfg_base(W, k);
            orn_swap_stage #(.W(W), .DW(DW), .K(k)) swap_i (
                .clk  (clk),
                .rst  (rst),
                .swap (act_cfg[BASE +: NPK]),
                .d    (lane_tap[l][k]),
                .q    (lane_tap[l][k+1])
            );
        end
    end

    assign dst_a = lane_tap[0][MCL];
    assign dst_b = lane_tap[1][MCL];
endmodule

// File: rtl/orn_row_link_chk.sv
module orn_row_link_chk
    import orn_pkg::*;
#(
    parameter int W   = 8,
    parameter int DW  = 16,
    parameter int MCL = 2
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic                                   cfg_shift,
    input logic                                   cfg_load,
    input logic [W*DW-1:0]                        src_data,
    input logic [total_cfg_bits(W, MCL)-1:0]      chain_q,
    input logic [total_cfg_bits(W, MCL)-1:0]      act_cfg,
    input logic [LANES-1:0][MCL:0][W-1:0][DW-1:0] lane_tap
);
    localparam int SW = DW + $clog2(W) + 1;

    function automatic logic [SW-1:0] row_sum(input logic [W-1:0][DW-1:0] v);
        logic [SW-1:0] acc;
        acc = '0;
        for (int j = 0; j < W; j++) acc += SW'(v[j]);
        return acc;
    endfunction

    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    logic [SW-1:0] src_sum;
    logic [LANES-1:0][MCL:0][SW-1:0] tap_sum;
    assign src_sum = row_sum(src_data);
    for (genvar l = 0; l < LANES; l++) begin : g_sl
        for (genvar k = 0; k <= MCL; k++) begin : g_sk
            assign tap_sum[l][k] = row_sum(lane_tap[l][k]);
        end
    end

    // R10
    steer_conserve_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> (SW'(tap_sum[0][0] + tap_sum[1][0]) == $past(src_sum, 2)));

    for (genvar l = 0; l < LANES; l++) begin : g_cl
        for (genvar k = 1; k <= MCL; k++) begin : g_ck
            // R10
            hop_conserve_chk: assert property (@(posedge clk) disable iff (rst)
                (warm >= 2'd2) |-> (tap_sum[l][k] == $past(tap_sum[l][k-1], 2)));
        end
    end

    for (genvar j = 0; j < W; j++) begin : g_ex
        // R3
        lane_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
            !((|lane_tap[0][0][j]) && (|lane_tap[1][0][j])));
    end

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(act_cfg));

    // R7
    chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_shift |=> $stable(chain_q));
endmodule

bind orn_row_link orn_row_link_chk #(.W(W), .DW(DW), .MCL(MCL)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_shift (cfg_shift),
    .cfg_load  (cfg_load),
    .src_data  (src_data),
    .chain_q   (chain_q),
    .act_cfg   (act_cfg),
    .lane_tap  (lane_tap)
);

// File: tb/orn_row_link_tb_top.sv
module orn_row_link_tb_top;
    import orn_pkg::*;

    localparam int W     = 8;
    localparam int DW    = 16;
    localparam int MCL   = 2;
    localparam int CFG_W = total_cfg_bits(W, MCL);
    localparam int LB    = lane_cfg_bits(W, MCL);
    localparam int LAT   = 2 * (MCL + 1);
    localparam int NVEC  = 6;

    localparam logic [CFG_W-1:0] CFG_TBL [NVEC] = '{
        22'h000000, 22'h0000FF, 22'h3FFFFF, 22'h2AAA55, 22'h155F0F, 22'h3C3C3C
    };
    localparam logic [W*DW-1:0] SRC_TBL [NVEC] = '{
        128'h0001_0002_0003_0004_0005_0006_0007_0008,
        128'hA0A0_B1B1_C2C2_D3D3_E4E4_F5F5_0606_1717,
        128'h1111_2222_3333_4444_5555_6666_7777_8888,
        128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_0FED,
        128'h8001_4002_2004_1008_0810_0420_0240_0180,
        128'h7F7F_0000_FFFF_0101_ABAB_5A5A_C3C3_3C3C
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_sdi = 1'b0;
    logic            cfg_shift = 1'b0;
    logic            cfg_load = 1'b0;
    logic            cfg_sdo;
    logic [W*DW-1:0] src_data = '0;
    logic [W*DW-1:0] dst_a;
    logic [W*DW-1:0] dst_b;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    orn_row_link #(.W(W), .DW(DW), .MCL(MCL)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_sdi   (cfg_sdi),
        .cfg_shift (cfg_shift),
        .cfg_load  (cfg_load),
        .cfg_sdo   (cfg_sdo),
        .src_data  (src_data),
        .dst_a     (dst_a),
        .dst_b     (dst_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_vec(input string req, input logic [W*DW-1:0] act,
                             input logic [W*DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic shift_in(input logic [CFG_W-1:0] v);
        for (int i = CFG_W - 1; i >= 0; i--) begin
            cfg_sdi   = v[i];
            cfg_shift = 1'b1;
            @(negedge clk);
        end
        cfg_shift = 1'b0;
        cfg_sdi   = 1'b0;
    endtask

    task automatic load_cfg();
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Expected routing from the steering and exchange rules (R3, R4, R6)
    task automatic route_model(input logic [CFG_W-1:0] c, input logic [W*DW-1:0] s,
                               output logic [W*DW-1:0] ea, output logic [W*DW-1:0] eb);
        logic [DW-1:0] ln [2][W];
        logic [DW-1:0] t;
        int base;
        for (int j = 0; j < W; j++) begin
            ln[0][j] = c[j] ? '0 : s[j*DW +: DW];
            ln[1][j] = c[j] ? s[j*DW +: DW] : '0;
        end
        for (int l = 0; l < 2; l++) begin
            base = W + l * LB;
            for (int k = 0; k < MCL; k++) begin
                for (int p = 0; p < (W - (k % 2)) / 2; p++) begin
                    if (c[base + p]) begin
                        t = ln[l][k%2 + 2*p];
                        ln[l][k%2 + 2*p] = ln[l][k%2 + 2*p + 1];
                        ln[l][k%2 + 2*p + 1] = t;
                    end
                end
                base += (W - (k % 2)) / 2;
            end
        end
        for (int j = 0; j < W; j++) begin
            ea[j*DW +: DW] = ln[0][j];
            eb[j*DW +: DW] = ln[1][j];
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [W*DW-1:0] ea, eb, last_a, last_b;
        logic [W*DW-1:0] pulse;
        int pos;

        tick(5);
        // R1: outputs cleared under reset
        check_vec("R1 dst_a in reset", dst_a, '0);
        check_vec("R1 dst_b in reset", dst_b, '0);
        rst = 1'b0;
        src_data = SRC_TBL[0];
        tick(LAT + 1);
        // R1: cleared setting routes straight to lane A
        check_vec("R1 default dst_a", dst_a, SRC_TBL[0]);
        check_vec("R1 default dst_b", dst_b, '0);

        // R2: single-cycle pulse latency
        src_data = '0;
        tick(LAT + 2);
        pulse = 128'h0F0F_1E1E_2D2D_3C3C_4B4B_5A5A_6969_7878;
        src_data = pulse;
        tick(1);
        src_data = '0;
        tick(LAT - 2);
        check_vec("R2 one edge early", dst_a, '0);
        tick(1);
        check_vec("R2 on time", dst_a, pulse);
        tick(1);
        check_vec("R2 one cycle only", dst_a, '0);

        // Table walk: R3 R4 R6 R8
        for (int e = 0; e < NVEC; e++) begin
            src_data = SRC_TBL[e];
            shift_in(CFG_TBL[e]);
            load_cfg();
            tick(LAT + 1);
            route_model(CFG_TBL[e], SRC_TBL[e], ea, eb);
            check_vec($sformatf("R3 R4 R6 R8 vector %0d dst_a", e), dst_a, ea);
            check_vec($sformatf("R3 R4 R6 R8 vector %0d dst_b", e), dst_b, eb);
            if (e == 2) begin
                // R5: every distinct source lands within MCL columns
                for (int j = 0; j < W; j++) begin
                    pos = -1;
                    for (int i = 0; i < W; i++)
                        if (dst_b[i*DW +: DW] == SRC_TBL[e][j*DW +: DW]) pos = i;
                    tests++;
                    if (pos < 0 || (pos > j ? pos - j : j - pos) > MCL) begin
                        fails++;
                        $display("FAIL R5 source %0d: got column %0d expected within %0d",
                                 j, pos, MCL);
                    end
                end
            end
            last_a = ea;
            last_b = eb;
        end

        // R7: shifting without a load leaves routing unchanged
        shift_in(CFG_TBL[1]);
        tick(LAT + 1);
        check_vec("R7 shift only dst_a", dst_a, last_a);
        check_vec("R7 shift only dst_b", dst_b, last_b);
        // R9: chain tail shows the MSB of the shifted vector
        check_bit("R9 sdo msb", cfg_sdo, CFG_TBL[1][CFG_W-1]);
        // R8: the load applies the shifted vector
        load_cfg();
        tick(LAT + 1);
        route_model(CFG_TBL[1], SRC_TBL[NVEC-1], ea, eb);
        check_vec("R8 after load dst_a", dst_a, ea);
        check_vec("R8 after load dst_b", dst_b, eb);
        // R9: one more shift exposes the next bit
        cfg_sdi = 1'b1;
        cfg_shift = 1'b1;
        tick(1);
        cfg_shift = 1'b0;
        check_bit("R9 sdo next bit", cfg_sdo, CFG_TBL[1][CFG_W-2]);

        // R1: reset in mid-run clears outputs and setting
        rst = 1'b1;
        tick(2);
        check_vec("R1 mid-run dst_a", dst_a, '0);
        check_vec("R1 mid-run dst_b", dst_b, '0);
        check_bit("R1 chain cleared", cfg_sdo, 1'b0);
        rst = 1'b0;
        src_data = SRC_TBL[3];
        tick(LAT + 1);
        check_vec("R1 post-reset dst_a", dst_a, SRC_TBL[3]);
        check_vec("R1 post-reset dst_b", dst_b, '0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule